// File: doc/BRIEF.md
# Excitation-Driven Flip-Flop Trio

This block holds three small clocked state machines side by side. Each one is written as the input equations of its flip-flop type, not as a state table. The first is a single D-type bit that takes the parity of its own value and two inputs. The second is a pair of JK-type bits steered by one input. The third is a pair of T-type bits steered by one input, with a product output taken from its state. Every flip-flop is a separate behavioural model of its kind: a D loads its data, a JK holds, sets, clears or toggles, and a T toggles when its input is 1. The top level applies the equations to those models.

All bits change on the rising clock edge and share one active-low clear. Asserting the clear empties every bit at once, without waiting for a clock edge. Releasing it passes through a short synchroniser, so all three machines start on the same edge. The inputs and outputs are plain level signals with no handshake: each circuit samples its inputs on every rising edge once it is out of reset. The present state of each machine is driven straight onto the outputs.

Top module: `excq_trio`

## Requirements
- R1: Out of reset, each rising edge loads `d_state` with the XOR of `d_state`, `d_x` and `d_y` sampled before that edge, so the bit is 1 when an odd number of the three are 1.
- R2: In the JK machine, bit A (`jk_state[1]`) is driven with J = B and K = B AND NOT `jk_x`, where B is `jk_state[0]`. This gives A(next) = A'B + AB' + A·x.
- R3: In the JK machine, bit B (`jk_state[0]`) is driven with J = NOT `jk_x` and K = A XOR `jk_x`. This gives B(next) = B'x' + ABx + A'Bx'.
- R4: Each JK flip-flop holds when J=0 and K=0, goes to 1 when J=1 and K=0, goes to 0 when J=0 and K=1, and inverts when J=1 and K=1. For example, B holds whenever `jk_x`=1 and A=1.
- R5: In the T machine, bit A (`t_state[1]`) is driven with T = B AND `t_x`, and bit B (`t_state[0]`) with T = `t_x`. Each bit follows Q(next) = T XOR Q.
- R6: `t_y` equals `t_state[1]` AND `t_state[0]` in the same cycle. It is combinational from the state, with no added register.
- R7: While `rst_n` is 0, every state bit and `t_y` read 0. This takes effect as soon as `rst_n` falls, with no clock edge needed, and holds whatever the data inputs are.
- R8: After `rst_n` rises, the state stays 0 through the first SYNC_STAGES rising edges (default 2). All three machines take their first update on the next edge, the same edge for all three.
- R9: Encoding: in each two-bit state output, bit 1 is flip-flop A and bit 0 is flip-flop B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all flip-flops |
| rst_n | input | 1 | Active-low clear; asserts at once, releases through the synchroniser |
| d_x | input | 1 | First data input of the D machine |
| d_y | input | 1 | Second data input of the D machine |
| jk_x | input | 1 | Steering input of the JK machine |
| t_x | input | 1 | Steering input of the T machine |
| d_state | output | 1 | Present state of the D machine |
| jk_state | output | 2 | Present state of the JK machine, {A, B} |
| t_state | output | 2 | Present state of the T machine, {A, B} |
| t_y | output | 1 | Product output of the T machine |

## Verification
Two of the block's functions can fall in the same cycle: the clear and normal capture. The bench provokes this in two ways. First, it drops `rst_n` in the middle of a clock period while all three machines hold non-zero state and their inputs would change that state. Second, it releases `rst_n` with inputs that would set bits on the very next edges. Judging is done in two ways. Direct probes, one time unit after the clear falls, require every output to be 0 before any edge arrives. Scoreboard entries then expect zeros for exactly SYNC_STAGES edges after release, and after that the closed-form next-state values on the same edge for all three machines.

// File: rtl/excq_pkg.sv
package excq_pkg;

  // Two-bit machine state, A in the upper bit.
  localparam int PAIR_W = 2;
  localparam int BIT_A  = 1;
  localparam int BIT_B  = 0;

  // Characteristic of a JK flip-flop.
  function automatic logic jk_char(input logic j, input logic k, input logic q);
    return (j & ~q) | (~k & q);
  endfunction

  // Characteristic of a T flip-flop.
  function automatic logic t_char(input logic t, input logic q);
    return t ^ q;
  endfunction

endpackage

// File: rtl/excq_rst_sync.sv
module excq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  // Asserts immediately, releases after STAGES rising edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/excq_dff.sv
module excq_dff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/excq_jkff.sv
module excq_jkff
  import excq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] j,
  input  logic [W-1:0] k,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = jk_char(j[i], k[i], q[i]);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/excq_tff.sv
module excq_tff
  import excq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] t,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = t_char(t[i], q[i]);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      q <= nxt;
    end
  end

endmodule

// File: rtl/excq_trio.sv
module excq_trio
  import excq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_x,
  input  logic              d_y,
  input  logic              jk_x,
  input  logic              t_x,
  output logic              d_state,
  output logic [PAIR_W-1:0] jk_state,
  output logic [PAIR_W-1:0] t_state,
  output logic              t_y
);

  logic run_n;

  excq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (run_n)
  );

  // D machine: parity of state and both inputs.
  logic [0:0] d_q;
  logic [0:0] d_in;
  assign d_in[0] = d_q[0] ^ d_x ^ d_y;

  excq_dff #(.W(1)) u_dbit (
    .clk   (clk),
    .clr_n (run_n),
    .d     (d_in),
    .q     (d_q)
  );

  // JK machine.
  logic [PAIR_W-1:0] jk_q;
  logic [PAIR_W-1:0] jk_j;
  logic [PAIR_W-1:0] jk_k;
  assign jk_j[BIT_A] = jk_q[BIT_B];
  assign jk_k[BIT_A] = jk_q[BIT_B] & ~jk_x;
  assign jk_j[BIT_B] = ~jk_x;
  assign jk_k[BIT_B] = jk_q[BIT_A] ^ jk_x;

  excq_jkff #(.W(PAIR_W)) u_jkpair (
    .clk   (clk),
    .clr_n (run_n),
    .j     (jk_j),
    .k     (jk_k),
    .q     (jk_q)
  );

  // T machine.
  logic [PAIR_W-1:0] t_q;
  logic [PAIR_W-1:0] t_t;
  assign t_t[BIT_A] = t_q[BIT_B] & t_x;
  assign t_t[BIT_B] = t_x;

  excq_tff #(.W(PAIR_W)) u_tpair (
    .clk   (clk),
    .clr_n (run_n),
    .t     (t_t),
    .q     (t_q)
  );

  assign d_state  = d_q[0];
  assign jk_state = jk_q;
  assign t_state  = t_q;
  assign t_y      = t_q[BIT_A] & t_q[BIT_B];

endmodule

// File: rtl/excq_trio_chk.sv
module excq_trio_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run_n,
  input logic       d_x,
  input logic       d_y,
  input logic       jk_x,
  input logic       t_x,
  input logic       d_state,
  input logic [1:0] jk_state,
  input logic [1:0] t_state,
  input logic       t_y
);

  localparam int CW = $clog2(SYNC_STAGES + 1) + 1;

  // Edges seen since rst_n rose, saturating.
  logic [CW-1:0] rel_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= '0;
    end else if (rel_cnt < CW'(SYNC_STAGES)) begin
      rel_cnt <= rel_cnt + 1'b1;
    end
  end

  p_d_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> d_state == ($past(d_state) ^ $past(d_x) ^ $past(d_y)));

  p_jk_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> jk_state[1] ==
      ((!$past(jk_state[1]) && $past(jk_state[0])) ||
       ($past(jk_state[1]) && !$past(jk_state[0])) ||
       ($past(jk_state[1]) && $past(jk_x))));

  p_jk_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> jk_state[0] ==
      ((!$past(jk_state[0]) && !$past(jk_x)) ||
       ($past(jk_state[1]) && $past(jk_state[0]) && $past(jk_x)) ||
       (!$past(jk_state[1]) && $past(jk_state[0]) && !$past(jk_x))));

  p_jk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && jk_x && jk_state[1]) |=> $stable(jk_state[0]));

  p_t_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> t_state[1] ==
      ($past(t_state[1]) ^ ($past(t_state[0]) & $past(t_x))));

  p_t_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> t_state[0] == ($past(t_state[0]) ^ $past(t_x)));

  p_y_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_n && t_y && !t_x) |=> t_y);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n |-> (!d_state && jk_state == 2'b00 && t_state == 2'b00 && !t_y));

  p_rel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt < CW'(SYNC_STAGES)) |-> !run_n);

  p_rel_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cnt >= CW'(SYNC_STAGES)) |-> run_n);

endmodule

bind excq_trio excq_trio_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_n    (run_n),
  .d_x      (d_x),
  .d_y      (d_y),
  .jk_x     (jk_x),
  .t_x      (t_x),
  .d_state  (d_state),
  .jk_state (jk_state),
  .t_state  (t_state),
  .t_y      (t_y)
);

// File: tb/excq_trio_bench.sv
module excq_trio_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk, rst_n, d_x, d_y, jk_x, t_x;
  logic d_state, t_y;
  logic [1:0] jk_state, t_state;

  excq_trio #(.SYNC_STAGES(SYNC)) u_excq_trio (
    .clk(clk), .rst_n(rst_n), .d_x(d_x), .d_y(d_y), .jk_x(jk_x), .t_x(t_x),
    .d_state(d_state), .jk_state(jk_state), .t_state(t_state), .t_y(t_y)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       d;
    logic [1:0] jk;
    logic [1:0] t;
    logic       ty;
    bit         frozen;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  bit m_d, m_ja, m_jb, m_ta, m_tb;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_zero(input string tag);
    chk(tag, {1'b0, d_state}, 2'b00);
    chk(tag, jk_state, 2'b00);
    chk(tag, t_state, 2'b00);
    chk(tag, {1'b0, t_y}, 2'b00);
  endtask

  // Driver: called at a falling edge; drives, predicts, waits one cycle.
  task automatic step(input bit dx, input bit dy, input bit jx, input bit tx, input bit frozen);
    exp_t e;
    bit a, b;
    d_x = dx; d_y = dy; jk_x = jx; t_x = tx;
    if (!frozen) begin
      m_d = m_d ^ dx ^ dy;
      a = m_ja; b = m_jb;
      m_ja = (!a && b) || (a && !b) || (a && jx);
      m_jb = (!b && !jx) || (a && b && jx) || (!a && b && !jx);
      a = m_ta; b = m_tb;
      m_ta = (a && !b) || (a && !tx) || (!a && b && tx);
      m_tb = tx ^ b;
    end
    e.d = m_d; e.jk = {m_ja, m_jb}; e.t = {m_ta, m_tb};
    e.ty = m_ta & m_tb; e.frozen = frozen;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares one item per rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.frozen) begin
        chk("R8 held after release d", {1'b0, d_state}, {1'b0, e.d});
        chk("R8 held after release jk", jk_state, e.jk);
        chk("R8 held after release t", t_state, e.t);
      end else begin
        chk("R1 d parity", {1'b0, d_state}, {1'b0, e.d});
        chk("R2 R4 R9 jk A bit1", {1'b0, jk_state[1]}, {1'b0, e.jk[1]});
        chk("R3 R4 R9 jk B bit0", {1'b0, jk_state[0]}, {1'b0, e.jk[0]});
        chk("R5 R9 t pair", t_state, e.t);
        chk("R6 t_y product", {1'b0, t_y}, {1'b0, e.ty});
      end
    end
  end

  task automatic clear_model();
    m_d = 0; m_ja = 0; m_jb = 0; m_ta = 0; m_tb = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; d_x = 1; d_y = 0; jk_x = 0; t_x = 1;
    clear_model();
    #2 rst_n = 1'b0;
    #1 chk_zero("R7 reset state");
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk_zero("R7 held in clear");
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC; i++) step(1, 0, 0, 1, 1);
    // All input combinations across many states.
    for (int i = 0; i < 256; i++) begin
      step(i[0], i[1] ^ i[6], i[2] ^ i[5], i[3] ^ i[4] ^ i[7], 0);
    end
    // Drive toward non-zero state, then clear mid-cycle (R7).
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    #2 rst_n = 1'b0;
    clear_model();
    #1 chk_zero("R7 async clear mid cycle");
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1 chk_zero("R7 clear ignores clock and data");
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC; i++) step(1, 0, 0, 1, 1);
    for (int i = 0; i < 64; i++) begin
      step(i[1], i[0], i[2] ^ i[0], i[3] | i[5], 0);
    end
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule